// File: doc/BRIEF.md
# Weighted-Sum Stimulus Accumulator

This block computes the stimulus current for every neuron of a fully connected spiking network once per update step. For each target neuron `i` it forms the sum over all source neurons `j` of a signed synaptic weight times the source's postsynaptic current. It scales that sum by one of two shift-built factors, adds a bias constant and saturates the result to the 18-bit fixed-point format of the neuron pipeline. A positive weight makes the source excite the target. A negative weight makes it inhibit the target.

Weights are signed integers held in on-chip RAM split into one bank per multiply lane. Several lanes each form one product per clock, and a combining adder folds the lane results into a running sum for the current target. The results leave as a stream of one value per target, in increasing target order. The first value is ready long before the sweep ends, so a downstream neuron pipeline can start on it early. A single-cycle done flag marks the last value. Weights are loaded through a plain address/data/write-enable port while the engine is idle.

Top module: `stim_accum`

## Requirements
- R1: For target `i`, the accumulated sum is the sum over `j` of `W[i][j] * Is[j]`. The weight for target `i` and source `j` sits at weight address `i*NUM_NEURONS + j`. `Is[j]` occupies bits `[j*18 +: 18]` of `isVec` as signed Q2.15. Weights are signed 8-bit integers.
- R2: With `modeSel` = 0 the sum is scaled by `(sum >>> 4) - (sum >>> 9)`. With `modeSel` = 1 it is scaled by `sum >>> 5`. Both shifts are arithmetic and round toward minus infinity.
- R3: The sign-extended `bias` is added after scaling. The result is clamped to the signed 18-bit range [-131072, 131071] and driven on `stimData`.
- R4: Suppose `start` is sampled high at clock edge E0 while idle, and let P = NUM_NEURONS/LANES. The stimulus for target `i` then appears with `stimValid` high for exactly one cycle after edge E0+i*P+P+2, and `stimIdx` equals `i` at that time. Targets appear in increasing order, each exactly once.
- R5: `busy` rises after E0 and falls after edge E0+B+2, where B = NUM_NEURONS²/LANES. `done` is high for exactly that one cycle, together with the last stimulus.
- R6: A `start` pulse that arrives while `busy` is high is ignored. It neither restarts nor lengthens the step.
- R7: A weight write presented while `busy` is high is ignored. The stored weight stays unchanged.
- R8: `isVec`, `bias` and `modeSel` are captured at the accepted start. Changing them during the step does not change that step's results.
- R9: After reset, `busy`, `stimValid` and `done` are low and `stimData` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a sweep when idle |
| modeSel | input | 1 | Scale select: 0 gives 2^-4 - 2^-9, 1 gives 2^-5 |
| bias | input | 18 | Signed Q2.15 bias constant |
| isVec | input | NUM_NEURONS*18 | Postsynaptic currents of all neurons, packed |
| wgtWe | input | 1 | Weight write enable |
| wgtAddr | input | log2(NUM_NEURONS²) | Weight address, target*NUM_NEURONS + source |
| wgtData | input | 8 | Signed weight |
| busy | output | 1 | Sweep in progress |
| stimValid | output | 1 | `stimData` and `stimIdx` are valid |
| stimIdx | output | log2(NUM_NEURONS) | Target neuron of the current value |
| stimData | output | 18 | Signed Q2.15 stimulus |
| done | output | 1 | One-cycle pulse with the final stimulus |

## Verification
A running sum that is not restarted at a target boundary corrupts the second target's value. That output appears 2P+2 cycles after start, so the first stream of any step with nonzero weights exposes it. A mis-steered bank or lane index corrupts the values of the same step, and each value is compared with a reference sum built from the requirement. A counter that restarts or stalls moves the valid slots, `done` or the fall of `busy` away from their exact cycles, which the bench pins to single cycles. Saturation in both directions, changed inputs and ignored writes and starts are checked on the step in which they occur or on the step right after.

// File: rtl/stim_accum_pkg.sv
package stim_accum_pkg;
  // Scale shifts: mode 0 uses a shift-and-subtract pair, mode 1 a single shift.
  localparam int ScaleHiShift = 4;
  localparam int ScaleLoShift = 9;
  localparam int ScaleAltShift = 5;

  typedef struct packed {
    logic capture;    // snapshot the inputs of the step
    logic beatValid;  // weight banks read this cycle
    logic firstBeat;  // first beat of a target row
    logic lastBeat;   // last beat of a target row
    logic sweepEnd;   // last beat of the whole sweep
  } accStrobe_t;
endpackage

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import stim_accum_pkg::*;
#(
  parameter int NUM_NEURONS = 16,
  parameter int LANES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output accStrobe_t strobe,
  output logic [$clog2(NUM_NEURONS*NUM_NEURONS/LANES)-1:0] beatAddr,
  output logic [((NUM_NEURONS/LANES) > 1 ? $clog2(NUM_NEURONS/LANES) : 1)-1:0] beatCol,
  output logic [$clog2(NUM_NEURONS)-1:0] beatTgt,
  output logic busy
);
  localparam int PerTgt = NUM_NEURONS / LANES;
  localparam int Beats = NUM_NEURONS * NUM_NEURONS / LANES;
  localparam int BeatW = $clog2(Beats);
  localparam int ColW = PerTgt > 1 ? $clog2(PerTgt) : 1;
  localparam int TgtW = $clog2(NUM_NEURONS);
  localparam int CntW = $clog2(Beats + 2) + 1;

  logic [CntW-1:0] cnt;
  logic busyReg;
  logic inSweep;

  always_ff @(posedge clk) begin
    if (rst) begin
      busyReg <= 1'b0;
      cnt <= '0;
    end else if (!busyReg) begin
      cnt <= '0;
      if (start) busyReg <= 1'b1;
    end else if (cnt == CntW'(Beats + 1)) begin
      busyReg <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    inSweep = busyReg && (int'(cnt) < Beats);
    strobe.capture = !busyReg && start;
    strobe.beatValid = inSweep;
    strobe.firstBeat = inSweep && ((int'(cnt) % PerTgt) == 0);
    strobe.lastBeat = inSweep && ((int'(cnt) % PerTgt) == PerTgt - 1);
    strobe.sweepEnd = inSweep && (int'(cnt) == Beats - 1);
    beatAddr = BeatW'(cnt);
    beatCol = ColW'(int'(cnt) % PerTgt);
    beatTgt = TgtW'(int'(cnt) / PerTgt);
  end

  assign busy = busyReg;
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import stim_accum_pkg::*;
#(
  parameter int NUM_NEURONS = 16,
  parameter int LANES = 4,
  parameter int DATA_W = 18,
  parameter int WGT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  accStrobe_t strobe,
  input  logic [$clog2(NUM_NEURONS*NUM_NEURONS/LANES)-1:0] beatAddr,
  input  logic [((NUM_NEURONS/LANES) > 1 ? $clog2(NUM_NEURONS/LANES) : 1)-1:0] beatCol,
  input  logic [$clog2(NUM_NEURONS)-1:0] beatTgt,
  input  logic modeSel,
  input  logic [DATA_W-1:0] bias,
  input  logic [NUM_NEURONS*DATA_W-1:0] isVec,
  input  logic wgtWe,
  input  logic [$clog2(NUM_NEURONS*NUM_NEURONS)-1:0] wgtAddr,
  input  logic [WGT_W-1:0] wgtData,
  output logic stimValid,
  output logic [$clog2(NUM_NEURONS)-1:0] stimIdx,
  output logic [DATA_W-1:0] stimData,
  output logic done
);
  localparam int PerTgt = NUM_NEURONS / LANES;
  localparam int BankDepth = NUM_NEURONS * NUM_NEURONS / LANES;
  localparam int BankAw = $clog2(BankDepth);
  localparam int ColW = PerTgt > 1 ? $clog2(PerTgt) : 1;
  localparam int TgtW = $clog2(NUM_NEURONS);
  localparam int AccW = DATA_W + WGT_W + TgtW + 1;
  localparam logic signed [AccW-1:0] SatHi = AccW'((64'sd1 <<< (DATA_W - 1)) - 1);
  localparam logic signed [AccW-1:0] SatLo = ~SatHi;

  // Input snapshot taken at the accepted start.
  logic signed [DATA_W-1:0] isSnap [NUM_NEURONS];
  logic signed [DATA_W-1:0] biasSnap;
  logic modeSnap;

  always_ff @(posedge clk) begin
    if (strobe.capture) begin
      for (int n = 0; n < NUM_NEURONS; n++) isSnap[n] <= isVec[n*DATA_W +: DATA_W];
      biasSnap <= bias;
      modeSnap <= modeSel;
    end
  end

  // Stage 1: bank read with beat flags aligned to the read data.
  logic s1Valid, s1First, s1Last, s1End;
  logic [ColW-1:0] s1Col;
  logic [TgtW-1:0] s1Tgt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Valid <= 1'b0;
      s1First <= 1'b0;
      s1Last <= 1'b0;
      s1End <= 1'b0;
      s1Col <= '0;
      s1Tgt <= '0;
    end else begin
      s1Valid <= strobe.beatValid;
      s1First <= strobe.firstBeat;
      s1Last <= strobe.lastBeat;
      s1End <= strobe.sweepEnd;
      s1Col <= beatCol;
      s1Tgt <= beatTgt;
    end
  end

  logic signed [AccW-1:0] laneProd [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [WGT_W-1:0] mem [BankDepth];
    logic signed [WGT_W-1:0] rdq;
    logic [TgtW-1:0] srcIdx;
    logic signed [AccW-1:0] wExt, iExt;

    always_ff @(posedge clk) begin
      if (wgtWe && (int'(wgtAddr) % LANES == l)) mem[BankAw'(int'(wgtAddr) / LANES)] <= wgtData;
      if (strobe.beatValid) rdq <= mem[beatAddr];
    end

    assign srcIdx = TgtW'(int'(s1Col) * LANES + l);
    assign wExt = AccW'(rdq);
    assign iExt = AccW'(isSnap[srcIdx]);
    assign laneProd[l] = wExt * iExt;
  end

  // Combining adder over the lanes.
  logic signed [AccW-1:0] beatSum;
  always_comb begin
    beatSum = '0;
    for (int l = 0; l < LANES; l++) beatSum = beatSum + laneProd[l];
  end

  // Stage 2: running sum per target row.
  logic signed [AccW-1:0] acc;
  logic s2Fire, s2End;
  logic [TgtW-1:0] s2Tgt;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      s2Fire <= 1'b0;
      s2End <= 1'b0;
      s2Tgt <= '0;
    end else begin
      if (s1Valid) acc <= s1First ? beatSum : acc + beatSum;
      s2Fire <= s1Valid && s1Last;
      s2End <= s1Valid && s1End;
      s2Tgt <= s1Tgt;
    end
  end

  // Scale, bias and clamp.
  logic signed [AccW-1:0] scaled, biased, clamped;
  always_comb begin
    if (modeSnap) scaled = acc >>> ScaleAltShift;
    else scaled = (acc >>> ScaleHiShift) - (acc >>> ScaleLoShift);
    biased = scaled + AccW'(biasSnap);
    if (biased > SatHi) clamped = SatHi;
    else if (biased < SatLo) clamped = SatLo;
    else clamped = biased;
  end

  // Stage 3: output register.
  always_ff @(posedge clk) begin
    if (rst) begin
      stimValid <= 1'b0;
      stimIdx <= '0;
      stimData <= '0;
      done <= 1'b0;
    end else begin
      stimValid <= s2Fire;
      done <= s2End;
      if (s2Fire) begin
        stimIdx <= s2Tgt;
        stimData <= clamped[DATA_W-1:0];
      end
    end
  end
endmodule

// File: rtl/stim_accum.sv
module stim_accum
  import stim_accum_pkg::*;
#(
  parameter int NUM_NEURONS = 16,
  parameter int LANES = 4,
  parameter int DATA_W = 18,
  parameter int WGT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic modeSel,
  input  logic [DATA_W-1:0] bias,
  input  logic [NUM_NEURONS*DATA_W-1:0] isVec,
  input  logic wgtWe,
  input  logic [$clog2(NUM_NEURONS*NUM_NEURONS)-1:0] wgtAddr,
  input  logic [WGT_W-1:0] wgtData,
  output logic busy,
  output logic stimValid,
  output logic [$clog2(NUM_NEURONS)-1:0] stimIdx,
  output logic [DATA_W-1:0] stimData,
  output logic done
);
  localparam int PerTgt = NUM_NEURONS / LANES;
  localparam int BeatW = $clog2(NUM_NEURONS * NUM_NEURONS / LANES);
  localparam int ColW = PerTgt > 1 ? $clog2(PerTgt) : 1;
  localparam int TgtW = $clog2(NUM_NEURONS);

  accStrobe_t strobe;
  logic [BeatW-1:0] beatAddr;
  logic [ColW-1:0] beatCol;
  logic [TgtW-1:0] beatTgt;
  logic wgtGate;

  assign wgtGate = wgtWe && !busy;

  acc_ctrl #(.NUM_NEURONS(NUM_NEURONS), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .strobe(strobe),
    .beatAddr(beatAddr), .beatCol(beatCol), .beatTgt(beatTgt), .busy(busy)
  );

  acc_datapath #(.NUM_NEURONS(NUM_NEURONS), .LANES(LANES), .DATA_W(DATA_W), .WGT_W(WGT_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .beatAddr(beatAddr), .beatCol(beatCol), .beatTgt(beatTgt),
    .modeSel(modeSel), .bias(bias), .isVec(isVec),
    .wgtWe(wgtGate), .wgtAddr(wgtAddr), .wgtData(wgtData),
    .stimValid(stimValid), .stimIdx(stimIdx), .stimData(stimData), .done(done)
  );
endmodule

// File: rtl/stim_accum_checker.sv
module stim_accum_checker #(
  parameter int NUM_NEURONS = 16,
  parameter int LANES = 4
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic stimValid,
  input logic [$clog2(NUM_NEURONS)-1:0] stimIdx,
  input logic done
);
  localparam int PerTgt = NUM_NEURONS / LANES;
  localparam int Beats = NUM_NEURONS * NUM_NEURONS / LANES;
  localparam int CycW = $clog2(Beats + 4) + 1;
  localparam int VcW = $clog2(NUM_NEURONS) + 2;

  logic [CycW-1:0] cycCnt;
  logic [VcW-1:0] validCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cycCnt <= '0;
      validCnt <= '0;
    end else begin
      if (start && !busy) cycCnt <= '0;
      else if (busy) cycCnt <= cycCnt + 1'b1;
      if (start && !busy) validCnt <= '0;
      else if (stimValid) validCnt <= validCnt + 1'b1;
    end
  end

  // R4: targets stream out in order, starting from zero
  p_idx_order_r4: assert property (@(posedge clk) disable iff (rst)
    stimValid |-> (int'(stimIdx) == int'(validCnt)));

  // R4: never more valid slots than targets in one step
  p_valid_count_r4: assert property (@(posedge clk) disable iff (rst)
    stimValid |-> (int'(validCnt) < NUM_NEURONS));

  if (PerTgt > 1) begin : g_gap
    // R4: valid pulses last one cycle
    p_valid_gap_r4: assert property (@(posedge clk) disable iff (rst)
      stimValid |=> !stimValid);
  end

  // R5: done marks the final target
  p_done_last_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (stimValid && int'(stimIdx) == NUM_NEURONS - 1));

  // R5: busy ends exactly with done
  p_busy_drop_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R6: a start while busy never stretches the step
  p_step_length_r6: assert property (@(posedge clk) disable iff (rst)
    busy |-> (int'(cycCnt) <= Beats + 1));
endmodule

bind stim_accum stim_accum_checker #(.NUM_NEURONS(NUM_NEURONS), .LANES(LANES)) u_checker (
  .clk(clk), .rst(rst), .start(start), .busy(busy),
  .stimValid(stimValid), .stimIdx(stimIdx), .done(done)
);

// File: tb/stim_accum_bench.sv
module stim_accum_bench;
  localparam int N = 16;
  localparam int LN = 4;
  localparam int DW = 18;
  localparam int WW = 8;
  localparam int P = N / LN;
  localparam int B = N * N / LN;
  localparam int NVEC = 9;
  // {weight pattern, current pattern, mode, bias}
  localparam int VEC [NVEC][4] = '{
    '{0, 0, 0, 0}, '{0, 0, 1, 100}, '{1, 0, 0, -500},
    '{1, 3, 1, 2000}, '{4, 2, 0, -3000}, '{4, 3, 1, 0},
    '{2, 1, 1, 0}, '{3, 1, 0, 0}, '{1, 2, 1, -131072}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic modeSel = 1'b0;
  logic [DW-1:0] bias = '0;
  logic [N*DW-1:0] isVec = '0;
  logic wgtWe = 1'b0;
  logic [$clog2(N*N)-1:0] wgtAddr = '0;
  logic [WW-1:0] wgtData = '0;
  logic busy, stimValid, done;
  logic [$clog2(N)-1:0] stimIdx;
  logic [DW-1:0] stimData;

  int checks = 0;
  int errors = 0;
  int wModel [N*N];
  longint expv [N];

  always #4 clk = ~clk;

  stim_accum #(.NUM_NEURONS(N), .LANES(LN), .DATA_W(DW), .WGT_W(WW)) u_stim_accum (
    .clk(clk), .rst(rst), .start(start), .modeSel(modeSel), .bias(bias), .isVec(isVec),
    .wgtWe(wgtWe), .wgtAddr(wgtAddr), .wgtData(wgtData),
    .busy(busy), .stimValid(stimValid), .stimIdx(stimIdx), .stimData(stimData), .done(done));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int patW(input int p, input int i, input int j);
    case (p)
      0: return (i == j) ? 127 : 0;
      1: return ((i * 7 + j * 3) % 17) - 8;
      2: return 127;
      3: return -128;
      default: return ((i ^ j) & 1) ? -37 : 53;
    endcase
  endfunction

  function automatic int patIs(input int p, input int j);
    case (p)
      0: return (j + 1) * 1000 - 8000;
      1: return 131071;
      2: return (j % 2) ? -20000 : 20000;
      default: return j * 4096 - 32768;
    endcase
  endfunction

  // Reference from R1-style sum, R2 scaling and R3 bias/clamp
  task automatic computeExpected();
    for (int i = 0; i < N; i++) begin
      longint sum = 0;
      longint s;
      for (int j = 0; j < N; j++)
        sum += longint'(wModel[i*N+j]) * longint'($signed(isVec[j*DW +: DW]));
      if (modeSel) s = sum >>> 5;
      else s = (sum >>> 4) - (sum >>> 9);
      s = s + longint'($signed(bias));
      if (s > 131071) s = 131071;
      if (s < -131072) s = -131072;
      expv[i] = s;
    end
  endtask

  task automatic loadWeights(input int p);
    for (int a = 0; a < N*N; a++) begin
      @(negedge clk);
      wgtWe = 1'b1;
      wgtAddr = ($clog2(N*N))'(a);
      wgtData = WW'(patW(p, a / N, a % N));
      wModel[a] = patW(p, a / N, a % N);
    end
    @(negedge clk);
    wgtWe = 1'b0;
  endtask

  task automatic setIs(input int p);
    for (int j = 0; j < N; j++) isVec[j*DW +: DW] = DW'(patIs(p, j));
  endtask

  // Run one step; optional disturbances during the sweep (R6, R7, R8).
  task automatic runStep(input bit dStart, input bit dInputs, input bit dWeight, input string tag);
    int nextIdx = 0;
    int doneSeen = 0;
    computeExpected();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int m = 0; m <= B + 12; m++) begin
      if (m > 0) @(negedge clk);
      if (dStart && m == 10) start = 1'b1;
      if (dStart && m == 11) start = 1'b0;
      if (dInputs && m == 5) begin
        isVec = ~isVec;
        bias = bias + 18'd1000;
        modeSel = ~modeSel;
      end
      if (dWeight && m == 20) begin
        wgtWe = 1'b1;
        wgtAddr = '0;
        wgtData = WW'(wModel[0] + 5);
      end
      if (dWeight && m == 21) wgtWe = 1'b0;
      if (m == 0) check(busy === 1'b1, "R5", {tag, " busy after start"}, longint'(busy), 1);
      if (m == B + 1) check(busy === 1'b1, "R5", {tag, " busy before end"}, longint'(busy), 1);
      if (m == B + 2) check(busy === 1'b0, "R5", {tag, " busy cleared"}, longint'(busy), 0);
      if (stimValid === 1'b1) begin
        check(nextIdx < N, "R4", {tag, " extra valid"}, nextIdx, N - 1);
        if (nextIdx < N) begin
          check(int'(stimIdx) == nextIdx, "R4", {tag, " index"}, longint'(stimIdx), nextIdx);
          check(m == nextIdx * P + P + 2, "R4", {tag, " valid cycle"}, m, nextIdx * P + P + 2);
          check(longint'($signed(stimData)) == expv[nextIdx], "R1/R2/R3", {tag, " value"},
                longint'($signed(stimData)), expv[nextIdx]);
        end
        nextIdx++;
      end
      if (done === 1'b1) begin
        doneSeen++;
        check(m == B + 2, "R5", {tag, " done cycle"}, m, B + 2);
        check(nextIdx == N, "R5", {tag, " done with last"}, nextIdx, N);
      end
    end
    check(nextIdx == N, "R4", {tag, " valid count"}, nextIdx, N);
    check(doneSeen == 1, "R5", {tag, " done count"}, doneSeen, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(busy === 1'b0, "R9", "busy in reset", longint'(busy), 0);
    check(stimValid === 1'b0, "R9", "valid in reset", longint'(stimValid), 0);
    check(done === 1'b0, "R9", "done in reset", longint'(done), 0);
    check(stimData === '0, "R9", "data in reset", longint'(stimData), 0);
    rst = 1'b0;
    @(negedge clk);
    check(busy === 1'b0 && stimValid === 1'b0, "R9", "idle after reset", longint'(busy), 0);

    // Vector table: R1, R2, R3 (incl. both saturation directions), R4, R5
    for (int v = 0; v < NVEC; v++) begin
      if (v == 0 || VEC[v][0] != VEC[v-1][0]) loadWeights(VEC[v][0]);
      setIs(VEC[v][1]);
      modeSel = VEC[v][2][0];
      bias = DW'(VEC[v][3]);
      runStep(1'b0, 1'b0, 1'b0, $sformatf("vec%0d", v));
    end

    // R6: start while busy is ignored
    loadWeights(4);
    setIs(0);
    modeSel = 1'b0;
    bias = DW'(250);
    runStep(1'b1, 1'b0, 1'b0, "R6 restart");
    repeat (2) @(negedge clk);
    check(busy === 1'b0, "R6", "no second step", longint'(busy), 0);

    // R8: inputs changed mid-sweep do not matter
    runStep(1'b0, 1'b1, 1'b0, "R8 inputs");

    // R7: weight write while busy ignored, seen on the next step
    setIs(3);
    runStep(1'b0, 1'b0, 1'b1, "R7 write");
    runStep(1'b0, 1'b0, 1'b0, "R7 after");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule